// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block decodes bus addresses for a peripheral window that software can move inside a 28-bit address space. A 16-bit configuration word holds an enable flag and the upper address bits of a 16 KB aligned window base. When the window is enabled, and its placement does not collide with the fixed ROM, RAM or internal peripheral regions, any bus access that lands inside it raises a window strobe. That strobe goes to the peripheral or user logic. While the strobe is high, the eight active-low chip selects that arrive from the external region decoder are all forced inactive, so the window outranks every external region.

The configuration word can be written any number of times while its enable bit stays clear. The first accepted write that sets the enable bit locks the word until reset. A small two-state machine tracks this. `ST_OPEN` is entered at reset. It moves to itself on a write with the enable bit clear, and to `ST_LOCKED` on a write with the enable bit set. `ST_LOCKED` is left only by reset. A mode input selects between a 64 MB space, where only address bits 25..0 take part in decoding, and a 256 MB space, where all 28 bits do. In the 256 MB space there is one extra forbidden region: an image of the RAM just below the 64 MB boundary. The window decode and the chip-select gating are combinational and valid in the same cycle as the address.

Top module: `pwin_decoder`

## Requirements
- R1: After reset, a full read of the configuration word returns 0000h, `win_hit` is 0, and `cs_n_out` equals `ext_cs_n`.
- R2: The configuration word is read or written only when `cfg_addr` equals FFFFF064h and `cfg_be` equals 2'b11. Any other access leaves the word unchanged, and a read that does not match returns 0000h.
- R3: Bit 14 of the configuration word always reads 0, even after a write that sets it.
- R4: Bits 13..0 of the word supply window base address bits 27..14, and the base's lower bits are zero. When the window is enabled and valid, an access with `bus_req`=1 whose address lies within the 16 KB window raises `win_hit`. An access outside the window does not raise it.
- R5: While bit 15 (enable) of the word is 0, `win_hit` stays 0.
- R6: The first accepted write with bit 15 set locks the word (`ST_LOCKED`). Every later write is ignored until reset. Accepted writes with bit 15 clear update the word and leave it unlocked.
- R7: While `win_hit` is 1, `cs_n_out` is all ones. Otherwise `cs_n_out` equals `ext_cs_n`.
- R8: A window that overlaps the ROM region (0 to 00FFFFFh), the RAM region (the 60 KB just below the peripheral region) or the internal peripheral region (the top 4 KB of the active space) is invalid and never hits.
- R9: With `mode_wide`=1 (256 MB), a window that overlaps the RAM image at 3FF0000h..3FFEFFFh is also invalid. A window just below that image stays valid.
- R10: With `mode_wide`=0 (64 MB), address bits 27..26 of both the bus address and the window base are ignored, so the window repeats every 64 MB. With `mode_wide`=1, all 28 bits are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 32 | Configuration access address |
| cfg_be | input | 2 | Configuration byte enables |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data (combinational) |
| mode_wide | input | 1 | 1 = 256 MB space, 0 = 64 MB space |
| bus_req | input | 1 | Bus access in progress |
| bus_addr | input | 28 | Bus access address |
| ext_cs_n | input | 8 | Active-low chip selects from the external region decoder |
| win_hit | output | 1 | Window access strobe |
| cs_n_out | output | 8 | Gated active-low chip selects |

## Verification
The assertions assume that `mode_wide` and the configuration word are stable while an access is being checked. They also assume that configuration writes come as single-cycle strobes that are sampled on the rising edge. The bench changes every input only on the falling clock edge and holds each configuration strobe for exactly one cycle. It compares the combinational outputs shortly after the inputs settle. Each scenario starts from its own reset, because the write-once lock would otherwise carry over from an earlier scenario.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    localparam int CFG_W   = 16;
    localparam int EN_BIT  = 15;
    localparam int RSV_BIT = 14;
endpackage

// File: rtl/pwin_cfg_reg.sv
module pwin_cfg_reg
    import pwin_pkg::*;
#(
    parameter logic [31:0] REG_ADDR = 32'hFFFF_F064,
    parameter int          PA_W     = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_rd,
    input  logic [31:0]         cfg_addr,
    input  logic [1:0]          cfg_be,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    output logic                win_en,
    output logic [PA_W-1:0]     win_pa
);
    localparam logic [CFG_W-1:0] KEEP_MASK =
        CFG_W'(1 << EN_BIT) | CFG_W'((1 << PA_W) - 1);

    lock_state_e          state_q, state_d;
    logic [CFG_W-1:0]     word_q;
    logic                 sel, wr_ok;

    assign sel   = (cfg_addr == REG_ADDR) && (cfg_be == 2'b11);
    assign wr_ok = cfg_wr && sel && (state_q == ST_OPEN);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (wr_ok && cfg_wdata[EN_BIT]) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // data register and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     word_q <= '0;
        else if (wr_ok) word_q <= cfg_wdata & KEEP_MASK;
    end

    always_comb begin
        cfg_rdata = (cfg_rd && sel) ? word_q : '0;
        win_en    = word_q[EN_BIT];
        win_pa    = word_q[PA_W-1:0];
    end

    AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOCKED |=> (state_q == ST_LOCKED) && $stable(word_q)); // R6
    AST_EN_MEANS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        word_q[EN_BIT] |-> state_q == ST_LOCKED); // R6
    AST_PARTIAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_be != 2'b11) |=> $stable(word_q)); // R2
    AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[RSV_BIT] == 1'b0); // R3
endmodule

// File: rtl/pwin_overlap.sv
module pwin_overlap #(
    parameter int                 ADDR_W    = 28,
    parameter int                 OFS_W     = 14,
    parameter int                 NARROW_W  = 26,
    parameter logic [ADDR_W-1:0]  ROM_LAST  = 28'h00F_FFFF,
    parameter logic [ADDR_W-1:0]  RAM_SIZE  = 28'h000_F000,
    parameter logic [ADDR_W-1:0]  PERI_SIZE = 28'h000_1000
) (
    input  logic                      mode_wide,
    input  logic [ADDR_W-OFS_W-1:0]   win_pa,
    output logic [ADDR_W-1:0]         win_base,
    output logic                      win_ok
);
    localparam int NREG = 4;
    localparam logic [ADDR_W-1:0] NARROW_TOP =
        {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [ADDR_W-1:0] WIDE_TOP = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] OFS_ONES =
        {{(ADDR_W-OFS_W){1'b0}}, {OFS_W{1'b1}}};

    logic [ADDR_W-1:0] top, wlast;
    logic [ADDR_W-1:0] lo [NREG];
    logic [ADDR_W-1:0] hi [NREG];
    logic [NREG-1:0]   act, ovl;

    always_comb begin
        top      = mode_wide ? WIDE_TOP : NARROW_TOP;
        win_base = {win_pa, {OFS_W{1'b0}}} & top;
        wlast    = win_base | OFS_ONES;
        // ROM
        lo[0] = '0;                                  hi[0] = ROM_LAST;
        // RAM
        lo[1] = top - PERI_SIZE - RAM_SIZE + 1'b1;   hi[1] = top - PERI_SIZE;
        // internal peripherals
        lo[2] = top - PERI_SIZE + 1'b1;              hi[2] = top;
        // RAM image below the 64 MB boundary (wide mode only)
        lo[3] = NARROW_TOP - PERI_SIZE - RAM_SIZE + 1'b1;
        hi[3] = NARROW_TOP - PERI_SIZE;
        act   = {mode_wide, 3'b111};
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_region
            assign ovl[g] = act[g] && (win_base <= hi[g]) && (wlast >= lo[g]);
        end
    endgenerate

    assign win_ok = ~|ovl;
endmodule

// File: rtl/pwin_cs_gate.sv
module pwin_cs_gate #(
    parameter int ADDR_W   = 28,
    parameter int OFS_W    = 14,
    parameter int NARROW_W = 26,
    parameter int NCS      = 8
) (
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              mode_wide,
    input  logic              win_en,
    input  logic              win_ok,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [NCS-1:0]    ext_cs_n,
    output logic              win_hit,
    output logic [NCS-1:0]    cs_n_out
);
    localparam logic [ADDR_W-1:0] NARROW_MASK =
        {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [ADDR_W-1:0] a_eff;

    always_comb begin
        a_eff   = mode_wide ? bus_addr : (bus_addr & NARROW_MASK);
        win_hit = bus_req && win_en && win_ok &&
                  (a_eff[ADDR_W-1:OFS_W] == win_base[ADDR_W-1:OFS_W]);
    end

    genvar i;
    generate
        for (i = 0; i < NCS; i++) begin : g_cs
            assign cs_n_out[i] = ext_cs_n[i] | win_hit;
        end
    endgenerate
endmodule

// File: rtl/pwin_decoder.sv
module pwin_decoder
    import pwin_pkg::*;
#(
    parameter int                 ADDR_W    = 28,
    parameter int                 OFS_W     = 14,
    parameter int                 NARROW_W  = 26,
    parameter int                 NCS       = 8,
    parameter logic [31:0]        REG_ADDR  = 32'hFFFF_F064,
    parameter logic [ADDR_W-1:0]  ROM_LAST  = 28'h00F_FFFF,
    parameter logic [ADDR_W-1:0]  RAM_SIZE  = 28'h000_F000,
    parameter logic [ADDR_W-1:0]  PERI_SIZE = 28'h000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [31:0]       cfg_addr,
    input  logic [1:0]        cfg_be,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              mode_wide,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NCS-1:0]    ext_cs_n,
    output logic              win_hit,
    output logic [NCS-1:0]    cs_n_out
);
    localparam int PA_W = ADDR_W - OFS_W;

    logic              win_en, win_ok;
    logic [PA_W-1:0]   win_pa;
    logic [ADDR_W-1:0] win_base;

    pwin_cfg_reg #(.REG_ADDR(REG_ADDR), .PA_W(PA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .win_en(win_en), .win_pa(win_pa)
    );

    pwin_overlap #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .NARROW_W(NARROW_W),
        .ROM_LAST(ROM_LAST), .RAM_SIZE(RAM_SIZE), .PERI_SIZE(PERI_SIZE)
    ) u_ovl (
        .mode_wide(mode_wide), .win_pa(win_pa),
        .win_base(win_base), .win_ok(win_ok)
    );

    pwin_cs_gate #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .NARROW_W(NARROW_W), .NCS(NCS)
    ) u_gate (
        .bus_req(bus_req), .bus_addr(bus_addr), .mode_wide(mode_wide),
        .win_en(win_en), .win_ok(win_ok), .win_base(win_base),
        .ext_cs_n(ext_cs_n), .win_hit(win_hit), .cs_n_out(cs_n_out)
    );

    AST_HIT_FORCES_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> cs_n_out == {NCS{1'b1}}); // R7
    AST_MISS_PASSES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> cs_n_out == ext_cs_n); // R7
    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> !win_hit); // R5
    AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !win_ok |-> !win_hit); // R8
endmodule

// File: tb/tb_pwin_decoder.sv
module tb_pwin_decoder;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] RA = 32'hFFFF_F064;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        mode_wide = 1'b1;
    logic        bus_req = 1'b0;
    logic [27:0] bus_addr = '0;
    logic [7:0]  ext_cs_n = 8'hFF;
    logic        win_hit;
    logic [7:0]  cs_n_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwin_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mode_wide(mode_wide), .bus_req(bus_req),
        .bus_addr(bus_addr), .ext_cs_n(ext_cs_n), .win_hit(win_hit),
        .cs_n_out(cs_n_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_wr = 0; cfg_rd = 0; bus_req = 0; mode_wide = 1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [31:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input logic [1:0] be,
                          input logic [15:0] exp);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_rd = 1'b1;
        #1;
        check(req, {16'h0, cfg_rdata}, {16'h0, exp});
        cfg_rd = 1'b0;
    endtask

    task automatic bus_chk(input string req, input logic wide, input logic [27:0] a,
                           input logic [7:0] ext, input logic exp_hit);
        @(negedge clk);
        mode_wide = wide; bus_addr = a; ext_cs_n = ext; bus_req = 1'b1;
        #1;
        check(req, {31'h0, win_hit}, {31'h0, exp_hit});
        check(req, {24'h0, cs_n_out}, {24'h0, (exp_hit ? 8'hFF : ext)});
        bus_req = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        rd_chk("R1", RA, 2'b11, 16'h0000);
        bus_chk("R1", 1'b1, 28'h0000000, 8'hA5, 1'b0);
    endtask

    task automatic t_access();
        do_reset();
        wr(RA, 2'b01, 16'h0040);
        rd_chk("R2", RA, 2'b11, 16'h0000);
        wr(RA + 2, 2'b11, 16'h0040);
        rd_chk("R2", RA, 2'b11, 16'h0000);
        wr(RA, 2'b11, 16'h0040);
        rd_chk("R2", RA, 2'b10, 16'h0000);
        rd_chk("R4", RA, 2'b11, 16'h0040);
        bus_chk("R5", 1'b1, 28'h0100000, 8'h5A, 1'b0);
    endtask

    task automatic t_bit14_and_decode();
        do_reset();
        wr(RA, 2'b11, 16'h4040);
        rd_chk("R3", RA, 2'b11, 16'h0040);
        wr(RA, 2'b11, 16'hC040);
        rd_chk("R3", RA, 2'b11, 16'h8040);
        bus_chk("R4", 1'b1, 28'h0100000, 8'h00, 1'b1);
        bus_chk("R4", 1'b1, 28'h0103FFF, 8'h12, 1'b1);
        bus_chk("R4", 1'b1, 28'h0104000, 8'h3C, 1'b0);
        bus_chk("R4", 1'b1, 28'h00FFFFF, 8'hC3, 1'b0);
        bus_chk("R7", 1'b1, 28'h0102000, 8'h00, 1'b1);
        bus_chk("R7", 1'b1, 28'h0200000, 8'h3C, 1'b0);
    endtask

    task automatic t_lock();
        do_reset();
        wr(RA, 2'b11, 16'h0080);
        wr(RA, 2'b11, 16'h8040);
        wr(RA, 2'b11, 16'h8080);
        rd_chk("R6", RA, 2'b11, 16'h8040);
        wr(RA, 2'b11, 16'h0000);
        rd_chk("R6", RA, 2'b11, 16'h8040);
        bus_chk("R6", 1'b1, 28'h0100010, 8'hF0, 1'b1);
        bus_chk("R6", 1'b1, 28'h0200010, 8'hF0, 1'b0);
    endtask

    task automatic t_overlap();
        do_reset();
        wr(RA, 2'b11, 16'h8003);           // 000C000h touches ROM
        bus_chk("R8", 1'b1, 28'h000C000, 8'h0F, 1'b0);
        do_reset();
        wr(RA, 2'b11, 16'hBFFF);           // FFFC000h: RAM and peripherals
        bus_chk("R8", 1'b1, 28'hFFFC000, 8'h0F, 1'b0);
        bus_chk("R8", 1'b0, 28'h3FFC000, 8'h0F, 1'b0);
    endtask

    task automatic t_mirror();
        do_reset();
        wr(RA, 2'b11, 16'h8FFC);           // 3FF0000h: RAM image in wide mode
        bus_chk("R9", 1'b1, 28'h3FF0000, 8'h77, 1'b0);
        do_reset();
        wr(RA, 2'b11, 16'h8FFB);           // 3FEC000h: just below the image
        bus_chk("R9", 1'b1, 28'h3FEC000, 8'h77, 1'b1);
        bus_chk("R9", 1'b0, 28'h3FEFFFF, 8'h77, 1'b1);
    endtask

    task automatic t_alias();
        do_reset();
        wr(RA, 2'b11, 16'h8041);           // 0104000h
        bus_chk("R10", 1'b0, 28'hC104010, 8'h81, 1'b1);
        bus_chk("R10", 1'b1, 28'hC104010, 8'h81, 1'b0);
        bus_chk("R10", 1'b1, 28'h0104010, 8'h81, 1'b1);
    endtask

    initial begin
        t_reset();
        t_access();
        t_bit14_and_decode();
        t_lock();
        t_overlap();
        t_mirror();
        t_alias();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule